// File: doc/BRIEF.md
# Push-Button Power Sequencer with Hibernate

This block is the control logic of a multi-rail power manager. A debounced, active-low push-button wakes the system. The block then raises rail enables in a fixed order, using digital power-good inputs and a millisecond strobe. It holds the processor in an active-low reset until rail 3 has been good for a programmable number of ticks. After that, control passes to the processor through two pins. A hold pin keeps rails 1 to 3 alive, and a run pin controls the auxiliary rails 4 and up.

Once the system is running, a button press pulls an active-low interrupt line to the processor. When the processor drops both pins, the block shuts the rails down. If software has first set a force-keep bit, rail 1 survives the shutdown and the block rests in a hibernate state. A second press starts the power-up again from hibernate. Software can write a ready bit that is kept through hibernate and cleared on a full power-off. Boot code reads this bit to tell a wake from a cold start.

Rail k is driven by `rail_en[k-1]` and reports on `pgood[k-1]`. All delays are counted in `ms_tick` strobes.

Top module: `pbseq_top`

## Requirements
- R1: From off, a debounced press raises `rail_en[2]` (rail 3) while `cpu_rst_n` stays low.
- R2: `rail_en[1]` (rail 2) rises during power-up only after `pgood[2]` has been high without a break for PG_WAIT ticks.
- R3: `cpu_rst_n` goes high only after `pgood[2]` has been high for RST_TICKS ticks, and only if hold or the button is asserted at that moment.
- R4: `rail_en[0]` (rail 1) is still low in the first cycle of power-up from off. It rises R1_DELAY ticks later.
- R5: While `hold_in` is high, rails 1 to 3 stay enabled after the button is released.
- R6: While running, `rail_en[RAILS-1:3]` follow `run_in`. They are low in every other state.
- R7: While running, low hold, run and button turn off rails 2 and up. Rail 1 stays on only if the force-keep bit is 1; this is hibernate. Clearing the bit in hibernate turns rail 1 off. A press from hibernate restarts power-up with rail 1 already on.
- R8: `btn_irq_n` is low while the debounced button is pressed in the running state, and high otherwise.
- R9: A pulse on `sw_we` writes `sw_force_d` to the force-keep bit and `sw_ready_d` to the ready bit. `ready_o` shows the ready bit. It keeps its value through hibernate, and it reads 0 after reset and after every entry to off.
- R10: If neither hold nor the button is asserted when the reset timer expires, the block returns to off with all rails low.
- R11: While running, if a rail that was enabled and had reported good loses `pgood`, `cpu_rst_n` goes low in the same cycle.
- R12: A button level that lasts fewer than DEB_TICKS ticks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| btn_n | input | 1 | Raw push-button, low when pressed |
| hold_in | input | 1 | Processor hold for rails 1 to 3 |
| run_in | input | 1 | Processor enable for rails 4 and up |
| pgood | input | RAILS | Power-good per rail |
| sw_we | input | 1 | Software write strobe |
| sw_force_d | input | 1 | Force-keep bit write data |
| sw_ready_d | input | 1 | Ready bit write data |
| rail_en | output | RAILS | Regulator enables |
| cpu_rst_n | output | 1 | Active-low processor reset |
| btn_irq_n | output | 1 | Active-low button interrupt |
| ready_o | output | 1 | Ready bit readback |

## Verification
The hardest state to reach is the wake from hibernate. To get there, the bench must bring the system up, hand it to the hold pin, set the force-keep and ready bits, and then drop both pins. Only after that can a second press start a power-up with rail 1 already on. The stimulus runs this whole chain in order. It then checks that the ready bit read after the second boot is still 1, and that it reads 0 after a later full power-off.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;
   typedef enum logic [1:0] {
      ST_OFF = 2'd0,
      ST_UP  = 2'd1,
      ST_RUN = 2'd2,
      ST_HIB = 2'd3
   } pbseq_state_e;
endpackage

// File: rtl/pbseq_btn_filter.sv
module pbseq_btn_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw_n,
   output logic pressed
);
   localparam int DW = (DEB_TICKS < 2) ? 1 : $clog2(DEB_TICKS);
   localparam logic [DW-1:0] LAST = DW'(DEB_TICKS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [DW-1:0]          stab_cnt;
   logic                   level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
   end

   assign level = ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pressed  <= 1'b0;
         stab_cnt <= '0;
      end else if (level == pressed) begin
         stab_cnt <= '0;
      end else if (tick) begin
         if (stab_cnt == LAST) begin
            pressed  <= level;
            stab_cnt <= '0;
         end else begin
            stab_cnt <= stab_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbseq_tickcnt.sv
module pbseq_tickcnt #(
   parameter int MAX = 4,
   localparam int CW = (MAX < 1) ? 1 : $clog2(MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] TOP = CW'(MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clr)                 count <= '0;
      else if (tick && count < TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/pbseq_pg_watch.sv
module pbseq_pg_watch #(
   parameter int RAILS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAILS-1:0] rail_en,
   input  logic [RAILS-1:0] pgood,
   output logic             fault
);
   logic [RAILS-1:0] seen_q;
   logic [RAILS-1:0] lost;

   for (genvar k = 0; k < RAILS; k++) begin : g_rail
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          seen_q[k] <= 1'b0;
         else if (!rail_en[k]) seen_q[k] <= 1'b0;
         else if (pgood[k])   seen_q[k] <= 1'b1;
      end
      assign lost[k] = seen_q[k] & rail_en[k] & ~pgood[k];
   end

   assign fault = |lost;
endmodule

// File: rtl/pbseq_fsm.sv
module pbseq_fsm
   import pbseq_pkg::*;
#(
   parameter int RAILS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn,
   input  logic             hold,
   input  logic             run_in,
   input  logic             force_on,
   input  logic             pg3,
   input  logic             r1_done,
   input  logic             r2_ok,
   input  logic             rst_done,
   output pbseq_state_e     state,
   output logic             clr_r1,
   output logic             clr_pg,
   output logic             enter_off,
   output logic [RAILS-1:0] rail_en
);
   pbseq_state_e nxt;
   logic from_hib;
   logic in_up, in_run, in_hib;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_OFF: if (btn) nxt = ST_UP;
         ST_HIB: begin
            if (!force_on) nxt = ST_OFF;
            else if (btn)  nxt = ST_UP;
         end
         ST_UP:  if (rst_done) nxt = (hold || btn) ? ST_RUN : ST_OFF;
         ST_RUN: if (!hold && !run_in && !btn) nxt = force_on ? ST_HIB : ST_OFF;
         default: nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_OFF;
         from_hib <= 1'b0;
      end else begin
         state <= nxt;
         if (state != ST_UP) from_hib <= (state == ST_HIB) && (nxt == ST_UP);
      end
   end

   assign in_up     = (state == ST_UP);
   assign in_run    = (state == ST_RUN);
   assign in_hib    = (state == ST_HIB);
   assign enter_off = (nxt == ST_OFF) && (state != ST_OFF);
   assign clr_r1    = !in_up;
   assign clr_pg    = !in_up || !pg3;

   assign rail_en[0] = in_run || in_hib || (in_up && (r1_done || from_hib));
   assign rail_en[1] = in_run || (in_up && r2_ok);
   assign rail_en[2] = in_run || in_up;

   for (genvar k = 3; k < RAILS; k++) begin : g_aux
      assign rail_en[k] = in_run && run_in;
   end
endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
   import pbseq_pkg::*;
#(
   parameter int RAILS       = 7,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 4,
   parameter int R1_DELAY    = 2,
   parameter int PG_WAIT     = 4,
   parameter int RST_TICKS   = 260
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             btn_n,
   input  logic             hold_in,
   input  logic             run_in,
   input  logic [RAILS-1:0] pgood,
   input  logic             sw_we,
   input  logic             sw_force_d,
   input  logic             sw_ready_d,
   output logic [RAILS-1:0] rail_en,
   output logic             cpu_rst_n,
   output logic             btn_irq_n,
   output logic             ready_o
);
   localparam int R1W = (R1_DELAY < 1) ? 1 : $clog2(R1_DELAY + 1);
   localparam int PGW = (RST_TICKS < 1) ? 1 : $clog2(RST_TICKS + 1);

   if (RAILS < 4)            begin : g_chk_rails $error("RAILS must be at least 4"); end
   if (SYNC_STAGES < 2)      begin : g_chk_sync  $error("SYNC_STAGES must be at least 2"); end
   if (DEB_TICKS < 1)        begin : g_chk_deb   $error("DEB_TICKS must be at least 1"); end
   if (R1_DELAY < 1)         begin : g_chk_r1    $error("R1_DELAY must be at least 1"); end
   if (PG_WAIT >= RST_TICKS) begin : g_chk_pg    $error("PG_WAIT must be below RST_TICKS"); end

   logic           btn_pressed;
   logic [R1W-1:0] r1_cnt;
   logic [PGW-1:0] pg_cnt;
   logic           clr_r1, clr_pg, enter_off, fault;
   logic           force_q, ready_q;
   pbseq_state_e   state;

   pbseq_btn_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_TICKS(DEB_TICKS)) u_btn (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .raw_n(btn_n), .pressed(btn_pressed)
   );

   pbseq_tickcnt #(.MAX(R1_DELAY)) u_r1_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr_r1), .tick(ms_tick), .count(r1_cnt)
   );

   pbseq_tickcnt #(.MAX(RST_TICKS)) u_pg_timer (
      .clk(clk), .rst_n(rst_n), .clr(clr_pg), .tick(ms_tick), .count(pg_cnt)
   );

   pbseq_fsm #(.RAILS(RAILS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .btn(btn_pressed), .hold(hold_in), .run_in(run_in),
      .force_on(force_q), .pg3(pgood[2]),
      .r1_done(r1_cnt == R1W'(R1_DELAY)),
      .r2_ok(pg_cnt >= PGW'(PG_WAIT)),
      .rst_done(pg_cnt == PGW'(RST_TICKS)),
      .state(state), .clr_r1(clr_r1), .clr_pg(clr_pg), .enter_off(enter_off),
      .rail_en(rail_en)
   );

   pbseq_pg_watch #(.RAILS(RAILS)) u_watch (
      .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .pgood(pgood), .fault(fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         if (sw_we) begin
            force_q <= sw_force_d;
            ready_q <= sw_ready_d;
         end
         if (enter_off) ready_q <= 1'b0;
      end
   end

   assign ready_o   = ready_q;
   assign cpu_rst_n = (state == ST_RUN) && !fault;
   assign btn_irq_n = !((state == ST_RUN) && btn_pressed);
endmodule

// File: rtl/pbseq_checker.sv
module pbseq_checker #(
   parameter int RAILS = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [RAILS-1:0] rail_en,
   input logic [RAILS-1:0] pgood,
   input logic             cpu_rst_n,
   input logic             btn_irq_n,
   input logic             hold_in,
   input logic             force_q
);
   assert_rail2_after_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[1]) |-> $past(pgood[2]));

   assert_reset_needs_rail3_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_n |-> rail_en[2] && rail_en[1] && rail_en[0]);

   assert_hold_keeps_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_in && rail_en[2] |=> rail_en[2]);

   assert_aux_needs_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|rail_en[RAILS-1:3]) |-> rail_en[2]);

   assert_no_keep_drops_rail1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !force_q && !rail_en[2] |=> !rail_en[0]);

   assert_irq_only_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !btn_irq_n |-> rail_en[2] && rail_en[1]);

   assert_fault_resets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pgood[2]) && rail_en[2] && $past(rail_en[2]) && $past(cpu_rst_n) |-> !cpu_rst_n);
endmodule

bind pbseq_top pbseq_checker #(.RAILS(RAILS)) u_checker (
   .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .pgood(pgood),
   .cpu_rst_n(cpu_rst_n), .btn_irq_n(btn_irq_n), .hold_in(hold_in), .force_q(force_q)
);

// File: tb/tb_pbseq_top.sv
module tb_pbseq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       btn_n = 1'b1;
   logic       hold_in = 1'b0;
   logic       run_in = 1'b0;
   logic [6:0] pgood = '0;
   logic       sw_we = 1'b0;
   logic       sw_force_d = 1'b0;
   logic       sw_ready_d = 1'b0;
   logic [6:0] rail_en;
   logic       cpu_rst_n, btn_irq_n, ready_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int tdiv = 0;

   typedef struct {
      string      req;
      logic [6:0] rail;
      logic       rst;
      logic       irq;
      logic       rdy;
   } exp_t;
   exp_t q[$];
   exp_t cur;

   pbseq_top dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n(btn_n), .hold_in(hold_in),
      .run_in(run_in), .pgood(pgood), .sw_we(sw_we), .sw_force_d(sw_force_d),
      .sw_ready_d(sw_ready_d), .rail_en(rail_en), .cpu_rst_n(cpu_rst_n),
      .btn_irq_n(btn_irq_n), .ready_o(ready_o)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
      ms_tick <= (tdiv == 3);
      cycles  <= cycles + 1;
   end

   always @(posedge clk) begin
      if (cycles == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // monitor: compares one expected item at each falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         cur = q.pop_front();
         checks++;
         if (rail_en !== cur.rail || cpu_rst_n !== cur.rst ||
             btn_irq_n !== cur.irq || ready_o !== cur.rdy) begin
            errors++;
            $display("FAIL %s: actual rail=%b rst_n=%b irq_n=%b ready=%b expected rail=%b rst_n=%b irq_n=%b ready=%b",
                     cur.req, rail_en, cpu_rst_n, btn_irq_n, ready_o,
                     cur.rail, cur.rst, cur.irq, cur.rdy);
         end
      end
   end

   task automatic expect_out(input string req, input logic [6:0] r, input logic s,
                             input logic i, input logic d);
      exp_t e;
      e.req = req; e.rail = r; e.rst = s; e.irq = i; e.rdy = d;
      q.push_back(e);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      wait_clk(4 * n);
   endtask

   task automatic wait_rail3;
      while (!rail_en[2]) @(negedge clk);
      #1;
   endtask

   task automatic sw_write(input logic f, input logic r);
      sw_force_d = f; sw_ready_d = r; sw_we = 1'b1;
      wait_clk(1);
      sw_we = 1'b0;
   endtask

   initial begin
      wait_clk(3);
      expect_out("reset R9", 7'b0000000, 1'b0, 1'b1, 1'b0);
      wait_clk(1);
      rst_n = 1'b1;
      wait_clk(2);

      // R12: one-tick glitch ignored
      btn_n = 1'b0; wait_clk(4); btn_n = 1'b1;
      ticks(12);
      expect_out("R12 glitch", 7'b0000000, 1'b0, 1'b1, 1'b0);
      wait_clk(1);

      // R1 / R4: first power-up cycle
      btn_n = 1'b0;
      wait_rail3();
      expect_out("R1 R4 first cycle", 7'b0000100, 1'b0, 1'b1, 1'b0);
      ticks(12);
      expect_out("R4 rail1 delayed", 7'b0000101, 1'b0, 1'b1, 1'b0);
      wait_clk(1);

      // R2: rail 2 waits for rail 3 good
      pgood = 7'b0000111;
      ticks(2);
      expect_out("R2 too early", 7'b0000101, 1'b0, 1'b1, 1'b0);
      ticks(4);
      expect_out("R2 after wait", 7'b0000111, 1'b0, 1'b1, 1'b0);
      wait_clk(1);

      // R10: release without hold, timer expires
      btn_n = 1'b1;
      ticks(270);
      expect_out("R10 back to off", 7'b0000000, 1'b0, 1'b1, 1'b0);
      wait_clk(1);

      // R3 / R5: full boot with hold
      btn_n = 1'b0;
      ticks(10);
      hold_in = 1'b1;
      btn_n = 1'b1;
      ticks(200);
      expect_out("R3 reset still low", 7'b0000111, 1'b0, 1'b1, 1'b0);
      ticks(80);
      expect_out("R3 R5 running", 7'b0000111, 1'b1, 1'b1, 1'b0);
      wait_clk(1);

      // R6: run pin controls aux rails
      run_in = 1'b1;
      wait_clk(1);
      expect_out("R6 aux on", 7'b1111111, 1'b1, 1'b1, 1'b0);
      wait_clk(1);
      pgood = 7'b1111111;
      wait_clk(3);

      // R8: interrupt on press while running
      btn_n = 1'b0;
      ticks(10);
      expect_out("R8 irq low", 7'b1111111, 1'b1, 1'b0, 1'b0);
      wait_clk(1);
      btn_n = 1'b1;
      ticks(10);
      expect_out("R8 irq high", 7'b1111111, 1'b1, 1'b1, 1'b0);
      wait_clk(1);

      // R11: rail fault reasserts reset
      pgood[4] = 1'b0;
      expect_out("R11 fault", 7'b1111111, 1'b0, 1'b1, 1'b0);
      wait_clk(1);
      pgood[4] = 1'b1;
      expect_out("R11 recover", 7'b1111111, 1'b1, 1'b1, 1'b0);
      wait_clk(1);
      run_in = 1'b0;
      wait_clk(1);
      expect_out("R6 aux off", 7'b0000111, 1'b1, 1'b1, 1'b0);
      wait_clk(1);
      run_in = 1'b1;
      wait_clk(1);

      // R9 write, R7 hibernate
      sw_write(1'b1, 1'b1);
      expect_out("R9 write", 7'b1111111, 1'b1, 1'b1, 1'b1);
      wait_clk(1);
      hold_in = 1'b0; run_in = 1'b0;
      wait_clk(3);
      expect_out("R7 hibernate", 7'b0000001, 1'b0, 1'b1, 1'b1);
      wait_clk(1);
      pgood = 7'b0000001;
      wait_clk(2);

      // R7 wake with rail 1 already on
      btn_n = 1'b0;
      wait_rail3();
      expect_out("R7 wake rail1 on", 7'b0000101, 1'b0, 1'b1, 1'b1);
      wait_clk(1);
      pgood = 7'b0000111;
      hold_in = 1'b1;
      ticks(8);
      btn_n = 1'b1;
      ticks(270);
      expect_out("R9 retained R5", 7'b0000111, 1'b1, 1'b1, 1'b1);
      wait_clk(1);

      // R7 full shutdown clears ready (R9)
      sw_write(1'b0, 1'b1);
      hold_in = 1'b0;
      wait_clk(3);
      expect_out("R7 R9 full off", 7'b0000000, 1'b0, 1'b1, 1'b0);
      wait_clk(1);

      // R7: clearing force in hibernate drops rail 1
      btn_n = 1'b0;
      ticks(10);
      hold_in = 1'b1;
      btn_n = 1'b1;
      ticks(270);
      sw_write(1'b1, 1'b0);
      hold_in = 1'b0;
      wait_clk(3);
      expect_out("R7 hib again", 7'b0000001, 1'b0, 1'b1, 1'b0);
      wait_clk(1);
      sw_write(1'b0, 1'b0);
      wait_clk(2);
      expect_out("R7 force cleared", 7'b0000000, 1'b0, 1'b1, 1'b0);
      wait_clk(3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule